// File: doc/BRIEF.md
# Exception Entry Frame Pusher

When a processor takes an exception, this block saves the caller-saved part of the interrupted context to the active stack. A single `start` strobe captures a snapshot of the inputs. These are the eight context values, both stack pointers, a select that picks which stack is active, the current mode and the exception number. The block then issues eight word writes on a simple request/acknowledge memory port.

The stack grows downward. If the chosen stack pointer is only 4-byte aligned, the frame is pushed 4 bytes lower so that the resulting stack pointer is 8-byte aligned, and the stacked status word records that this happened. When the last write is accepted, the block pulses `done` and presents two results: the new value for the selected stack pointer and an encoded return token for the link register. A bus error on any of the frame writes does not stop the sequence. It is reported once, as a fault strobe that comes with `done`.

Top module: `exc_frame_pusher`

## Requirements
- R1: On a cycle where `start` is high and the block is idle, it captures all inputs and takes the stack pointer from `psp_in` when `sp_sel`=1, otherwise from `msp_in`.
- R2: Frame layout: R0 sits at the frame base, followed by R1, R2, R3, R12, LR and the return address at +4 through +24, and the status word at +28. The writes are issued in the order status word, return address, LR, R12, R3, R2, R1, R0, so the addresses fall by 4 from each write to the next.
- R3: If bit 2 of the captured SP is 1, the frame base is SP-36. Otherwise the base is SP-32. The base is always a multiple of 8.
- R4: In the stacked status word, bits [31:10] come from `psr_in`, bit 9 is 1 exactly when the realignment of R3 was applied, and bits [8:0] equal `exc_num`.
- R5: `new_sp` equals the frame base and is valid during the `done` cycle.
- R6: In the return token, bits [31:24] are 0xFF, bit 4 is 1, bit 3 equals `thread_mode`, bit 2 equals `sp_sel`, and all other bits are 0. The token is valid during the `done` cycle.
- R7: Each cycle where both `mem_req` and `mem_ack` are high completes exactly one write. While `mem_ack` is low, `mem_addr` and `mem_wdata` hold steady.
- R8: `done` is high for exactly one cycle, the cycle after the eighth write is accepted. In that cycle `mem_req` is already low. `new_sp` and `exc_token` keep their values until the next `done`.
- R9: `mem_err` is sampled only together with `mem_ack`. After an error the remaining writes still complete. `stack_fault` is high only in the `done` cycle, and only if at least one write of that frame had an error.
- R10: A `start` pulse while a frame is being pushed is ignored. The frame in progress keeps its captured values and its count of eight writes.
- R11: While reset is held and after it is released, `mem_req`, `done` and `stack_fault` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin pushing a frame |
| r0_in | input | 32 | Context register R0 |
| r1_in | input | 32 | Context register R1 |
| r2_in | input | 32 | Context register R2 |
| r3_in | input | 32 | Context register R3 |
| r12_in | input | 32 | Context register R12 |
| lr_in | input | 32 | Link register of the interrupted code |
| ret_addr_in | input | 32 | Return address |
| psr_in | input | 32 | Program status word; bits [9:0] are replaced |
| msp_in | input | AW | Main stack pointer |
| psp_in | input | AW | Process stack pointer |
| sp_sel | input | 1 | 0 = main stack, 1 = process stack |
| thread_mode | input | 1 | 0 = handler mode, 1 = thread mode |
| exc_num | input | 9 | Current exception number |
| mem_req | output | 1 | Write request |
| mem_addr | output | AW | Byte address of the word |
| mem_wdata | output | 32 | Word to write |
| mem_ack | input | 1 | Write accepted this cycle |
| mem_err | input | 1 | Accepted write had a bus error |
| done | output | 1 | Frame complete (one cycle) |
| new_sp | output | AW | Updated value for the selected stack pointer |
| exc_token | output | 32 | Encoded return token for the link register |
| stack_fault | output | 1 | Stacking bus error occurred (with done) |

## Verification
The bench runs frames from an 8-aligned main stack and from a process stack that is only 4-aligned. A design that ignored alignment would leave `new_sp` 4 bytes high and bit 9 clear. A design that read bit 9 from `psr_in` would be caught by a status word that arrives with bit 9 already set. Wait states on the acknowledge expose an address that advances without an acknowledge, and a reversed push order shows up as a write log that rises instead of falling. An error injected mid-frame checks that the sequence does not abort early and that the fault appears only with `done`. A `start` pulse with changed inputs, sent while a frame is in progress, would corrupt the frame or restart it if it were not ignored.

// File: rtl/exc_frame_pusher.sv
module exc_frame_pusher #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [31:0]   r0_in,
  input  logic [31:0]   r1_in,
  input  logic [31:0]   r2_in,
  input  logic [31:0]   r3_in,
  input  logic [31:0]   r12_in,
  input  logic [31:0]   lr_in,
  input  logic [31:0]   ret_addr_in,
  input  logic [31:0]   psr_in,
  input  logic [AW-1:0] msp_in,
  input  logic [AW-1:0] psp_in,
  input  logic          sp_sel,
  input  logic          thread_mode,
  input  logic [8:0]    exc_num,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic          mem_err,
  output logic          done,
  output logic [AW-1:0] new_sp,
  output logic [31:0]   exc_token,
  output logic          stack_fault
);
  localparam int NWORDS = 8;
  localparam int IW = $clog2(NWORDS);
  localparam logic [AW-1:0] FRAME_BYTES = AW'(NWORDS * 4);

  logic          busy;
  logic [IW-1:0] idx;
  logic [AW-1:0] base_q;
  logic [31:0]   token_q;
  logic          err_acc;
  logic [31:0]   frame_q [NWORDS];

  logic [AW-1:0] sp_cur;
  logic          realign;
  logic [AW-1:0] base_nxt;
  logic          last_beat;

  assign sp_cur    = sp_sel ? psp_in : msp_in;
  assign realign   = sp_cur[2];
  assign base_nxt  = sp_cur - FRAME_BYTES - (realign ? AW'(4) : AW'(0));
  assign last_beat = busy && mem_ack && (idx == '0);

  assign mem_req   = busy;
  assign mem_addr  = base_q + AW'({idx, 2'b00});
  assign mem_wdata = frame_q[idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      idx         <= '0;
      base_q      <= '0;
      token_q     <= '0;
      err_acc     <= 1'b0;
      done        <= 1'b0;
      stack_fault <= 1'b0;
      new_sp      <= '0;
      exc_token   <= '0;
      for (int i = 0; i < NWORDS; i++) frame_q[i] <= '0;
    end else begin
      done        <= 1'b0;
      stack_fault <= 1'b0;
      if (!busy && start) begin
        busy       <= 1'b1;
        idx        <= IW'(NWORDS - 1);
        base_q     <= base_nxt;
        err_acc    <= 1'b0;
        token_q    <= {8'hFF, 19'd0, 1'b1, thread_mode, sp_sel, 2'b00};
        frame_q[0] <= r0_in;
        frame_q[1] <= r1_in;
        frame_q[2] <= r2_in;
        frame_q[3] <= r3_in;
        frame_q[4] <= r12_in;
        frame_q[5] <= lr_in;
        frame_q[6] <= ret_addr_in;
        frame_q[7] <= {psr_in[31:10], realign, exc_num};
      end else if (busy && mem_ack) begin
        err_acc <= err_acc | mem_err;
        if (last_beat) begin
          busy        <= 1'b0;
          done        <= 1'b1;
          stack_fault <= err_acc | mem_err;
          new_sp      <= base_q;
          exc_token   <= token_q;
        end else begin
          idx <= idx - 1'b1;
        end
      end
    end
  end

  p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata)));

  p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && $past(mem_req) && mem_req == $past(mem_req) && idx != IW'(NWORDS - 1))
    |-> (mem_addr[1:0] == 2'b00));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_after_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!mem_req && $past(mem_req) && $past(mem_ack)));

  p_fault_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stack_fault |-> done);

  p_token_shape_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (exc_token[31:24] == 8'hFF && exc_token[4] && exc_token[23:5] == '0
              && exc_token[1:0] == 2'b00));

  p_sp_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(base_q[1:0]) == 2'b00) |-> (new_sp[2:0] == 3'b000));
endmodule

// File: tb/tb_exc_frame_pusher.sv
module tb_exc_frame_pusher;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [31:0] r0_i, r1_i, r2_i, r3_i, r12_i, lr_i, ra_i, psr_i;
  logic [31:0] msp_i, psp_i;
  logic sel_i, thr_i;
  logic [8:0] exc_i;
  logic mem_req, mem_ack, mem_err, done, stack_fault;
  logic [31:0] mem_addr, mem_wdata, new_sp, exc_token;

  always #10 clk = ~clk;

  exc_frame_pusher #(.AW(32)) dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .r0_in(r0_i), .r1_in(r1_i), .r2_in(r2_i), .r3_in(r3_i), .r12_in(r12_i),
    .lr_in(lr_i), .ret_addr_in(ra_i), .psr_in(psr_i),
    .msp_in(msp_i), .psp_in(psp_i), .sp_sel(sel_i), .thread_mode(thr_i),
    .exc_num(exc_i),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_err(mem_err),
    .done(done), .new_sp(new_sp), .exc_token(exc_token), .stack_fault(stack_fault)
  );

  int errors = 0;
  int checks = 0;

  int stall = 0;
  int stall_cnt = 0;
  int err_at = -1;
  int nlog = 0;
  logic [31:0] addr_log [16];
  logic [31:0] data_log [16];
  logic        moved_early = 1'b0;
  logic [31:0] held_addr;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    mem_ack = 1'b0;
    mem_err = 1'b0;
    if (rst_n && mem_req) begin
      if (stall_cnt > 0 && mem_addr != held_addr) moved_early = 1'b1;
      held_addr = mem_addr;
      if (stall_cnt < stall) begin
        stall_cnt++;
      end else begin
        stall_cnt = 0;
        mem_ack = 1'b1;
        mem_err = (nlog == err_at);
        if (nlog < 16) begin
          addr_log[nlog] = mem_addr;
          data_log[nlog] = mem_wdata;
        end
        nlog++;
      end
    end
  end

  task automatic push_and_check(input string name, input bit inject);
    logic [31:0] sp, base, psr_exp, tok_exp;
    logic [31:0] exp_words [8];
    bit realign;
    int dones, faults_early, cyc;
    sp = sel_i ? psp_i : msp_i;
    realign = sp[2];
    base = sp - 32 - (realign ? 32'd4 : 32'd0);
    psr_exp = {psr_i[31:10], realign, exc_i};
    tok_exp = {8'hFF, 19'd0, 1'b1, thr_i, sel_i, 2'b00};
    exp_words[0] = r0_i;  exp_words[1] = r1_i;  exp_words[2] = r2_i;
    exp_words[3] = r3_i;  exp_words[4] = r12_i; exp_words[5] = lr_i;
    exp_words[6] = ra_i;  exp_words[7] = psr_exp;
    nlog = 0; stall_cnt = 0; moved_early = 1'b0;
    dones = 0; faults_early = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    cyc = 0;
    while (!done && cyc < 200) begin
      if (inject && cyc == 3) begin
        r0_i = 32'hBAD0BAD0; msp_i = 32'h10; psp_i = 32'h10; start = 1'b1;
      end else start = 1'b0;
      if (stack_fault) faults_early++;
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    chk(done == 1'b1, {name, " R8 done seen"}, 32'(done), 1);
    chk(mem_req == 1'b0, {name, " R8 req low at done"}, 32'(mem_req), 0);
    chk(nlog == 8, {name, " R7 R10 write count"}, 32'(nlog), 8);
    for (int k = 0; k < 8 && k < nlog; k++) begin
      chk(addr_log[k] == base + 32'((7 - k) * 4), {name, " R2 R3 address"}, addr_log[k], base + 32'((7 - k) * 4));
      chk(data_log[k] == exp_words[7 - k], {name, " R2 R4 R1 data"}, data_log[k], exp_words[7 - k]);
    end
    chk(new_sp == base, {name, " R5 new_sp"}, new_sp, base);
    chk(new_sp[2:0] == 3'b000, {name, " R3 alignment"}, new_sp, {new_sp[31:3], 3'b000});
    chk(exc_token == tok_exp, {name, " R6 token"}, exc_token, tok_exp);
    chk(stack_fault == (err_at >= 0 && err_at < 8), {name, " R9 fault at done"}, 32'(stack_fault), 32'(err_at >= 0 && err_at < 8));
    chk(faults_early == 0, {name, " R9 no early fault"}, 32'(faults_early), 0);
    chk(!moved_early, {name, " R7 hold while stalled"}, 32'(moved_early), 0);
    @(negedge clk);
    chk(done == 1'b0 && stack_fault == 1'b0, {name, " R8 R9 single pulse"}, 32'({done, stack_fault}), 0);
    chk(new_sp == base && exc_token == tok_exp, {name, " R8 results held"}, new_sp, base);
    @(negedge clk);
    chk(nlog == 8, {name, " R7 no extra writes"}, 32'(nlog), 8);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(mem_req == 0 && done == 0 && stack_fault == 0, "R11 outputs during reset", 32'({mem_req, done, stack_fault}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(mem_req == 0 && done == 0 && stack_fault == 0, "R11 outputs after reset", 32'({mem_req, done, stack_fault}), 0);
  endtask

  task automatic t_main_aligned();
    r0_i = 32'h7; r1_i = 32'hA; r2_i = 32'hE000ED00; r3_i = 32'h00270000;
    r12_i = 32'h0; lr_i = 32'h2E7; ra_i = 32'h2F2; psr_i = 32'h690002FF;
    msp_i = 32'h2003FFF0; psp_i = 32'h20001004; sel_i = 0; thr_i = 0; exc_i = 9'd3;
    stall = 0; err_at = -1;
    push_and_check("main_aligned", 1'b0);
  endtask

  task automatic t_process_realign();
    r0_i = 32'h11111111; r1_i = 32'h22222222; r2_i = 32'h33333333; r3_i = 32'h44444444;
    r12_i = 32'hCCCC0012; lr_i = 32'h0800ABCD; ra_i = 32'h08001234; psr_i = 32'hF10F0000;
    msp_i = 32'h2003FFF0; psp_i = 32'h20001004; sel_i = 1; thr_i = 1; exc_i = 9'h1A5;
    stall = 2; err_at = -1;
    push_and_check("process_realign", 1'b0);
  endtask

  task automatic t_bus_error();
    r0_i = 32'hA0; r1_i = 32'hA1; r2_i = 32'hA2; r3_i = 32'hA3;
    r12_i = 32'hAC; lr_i = 32'hAE; ra_i = 32'hAF; psr_i = 32'h01000000;
    msp_i = 32'h20000404; psp_i = 32'h0; sel_i = 0; thr_i = 1; exc_i = 9'd5;
    stall = 1; err_at = 3;
    push_and_check("bus_error", 1'b0);
  endtask

  task automatic t_start_busy();
    r0_i = 32'h5A5A5A5A; r1_i = 32'h1; r2_i = 32'h2; r3_i = 32'h3;
    r12_i = 32'hC; lr_i = 32'hE; ra_i = 32'hF; psr_i = 32'h80000200;
    msp_i = 32'h0; psp_i = 32'h30000000; sel_i = 1; thr_i = 0; exc_i = 9'd16;
    stall = 1; err_at = -1;
    push_and_check("start_while_busy R10", 1'b1);
  endtask

  initial begin
    mem_ack = 1'b0; mem_err = 1'b0;
    r0_i = 0; r1_i = 0; r2_i = 0; r3_i = 0; r12_i = 0; lr_i = 0; ra_i = 0; psr_i = 0;
    msp_i = 0; psp_i = 0; sel_i = 0; thr_i = 0; exc_i = 0;
    t_reset();
    t_main_aligned();
    t_process_realign();
    t_bus_error();
    t_start_busy();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule